// File: doc/BRIEF.md
# External Edge Interrupt Controller

This block turns transitions on external signals into interrupt requests and event pulses for a processor subsystem. It watches 23 request lines. Sixteen of them come from general-purpose pins: each of these lines picks the pin of the same index from one of eight ports. The remaining seven lines come straight from other on-chip sources. Each line has its own edge detector, which can be set to fire on a rising edge, a falling edge or both. An input pulse shorter than one clock period is still caught, because the first capture stage is clocked by the line itself.

A detected edge, or a software trigger, becomes a request. The request sets a sticky pending bit when the line's interrupt enable is set. Separately, it produces a one-cycle event pulse when the line's event enable is set. Software clears a pending bit by writing 1 to it. All configuration is reached through a simple synchronous register bus. A read returns the addressed word one clock after the address is presented.

Top module: `xirq_ctrl`

## Requirements
- R1: Each of the 23 lines has a rising enable (register RISE, word address 2, bit = line) and a falling enable (register FALL, address 3). A low-to-high transition makes a request only when the rising bit is 1. A high-to-low transition makes a request only when the falling bit is 1. With both bits set, either transition makes a request. With neither bit set, transitions are ignored.
- R2: A transition is detected even when the line returns to its previous level within less than one clock period. The request takes effect at the third rising clock edge after the transition.
- R3: `irq_req[i]` is 1 exactly while pending bit i and interrupt enable bit i (register INT_EN, address 0) are both 1.
- R4: A request on line i drives `evt_pulse[i]` high for exactly one cycle, starting at the edge where the request takes effect, if event enable bit i (register EVT_EN, address 1) is 1. This does not depend on INT_EN. The event enable has no effect on the pending bit.
- R5: A pending bit (register PEND, address 5) is set by a request only while its INT_EN bit is 1. Writing 1 to a PEND bit clears it. Writing 0 has no effect. If a request and a clear meet on the same edge, the bit ends up set.
- R6: Writing 1 to a bit of register SWTRIG (address 4) that currently reads 0 makes a request on that line at the write edge. The bit then reads 1 until the matching PEND bit is written with 1. Writing 1 to a bit that already reads 1 makes no new request.
- R7: Line i (0 to 15) follows `gpio_in[p*16+i]`, where p is a 3-bit port field held in bits [4j+2:4j] of register SEL0 (address 6, lines 0 to 7, j = i) or SEL1 (address 7, lines 8 to 15, j = i-8). Pins of the other ports have no effect on the line. Lines 16 to 22 follow `aux_in[i-16]`.
- R8: `bus_rdata` holds the word at `bus_addr` one clock after the address is presented. Unused bits read 0, and INT_EN, EVT_EN, RISE, FALL, SWTRIG and PEND return only bits 22:0.
- R9: While `rst_n` is low at a clock edge, every register, pending bit and output is cleared to 0, so all lines are masked.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus and logic clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_we | input | 1 | Write strobe for the register bus |
| bus_addr | input | 4 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| gpio_in | input | 128 | Pin inputs, port p pin i at bit p*16+i |
| aux_in | input | 7 | Direct sources of lines 16 to 22 |
| irq_req | output | 23 | Per-line interrupt request level |
| evt_pulse | output | 23 | Per-line one-cycle event pulse |

## Verification
A corrupted pending bit shows on `irq_req` in the same cycle whenever the line is enabled, and a lost or extra request shows on `evt_pulse` at the third clock edge after the input transition. A wrong trigger enable or port field therefore appears as a missing or spurious pulse at exactly that edge. A stuck software-trigger bit is exposed by the absence of an event on a later trigger, and by reading the register back after a clear. The sweeps cover every line in every trigger mode and every line from every port, so any mis-wired bit reaches the ports within a few cycles of its stimulus.

// File: rtl/xirq_pkg.sv
// Shared constants for the external edge interrupt controller.
// Assumes a 32-bit register bus with word addresses.
package xirq_pkg;

    localparam int DATA_W         = 32;
    localparam int ADDR_W         = 4;
    localparam int SEL_FIELD_W    = 4;
    localparam int FIELDS_PER_REG = DATA_W / SEL_FIELD_W;

    // Word addresses of the register file; selection words follow A_SEL0.
    typedef enum logic [ADDR_W-1:0] {
        A_INT_EN = 4'd0,
        A_EVT_EN = 4'd1,
        A_RISE   = 4'd2,
        A_FALL   = 4'd3,
        A_SWTRIG = 4'd4,
        A_PEND   = 4'd5,
        A_SEL0   = 4'd6
    } reg_addr_e;

endpackage

// File: rtl/xirq_src_mux.sv
// Source selection: each pin-sourced line takes the same-indexed pin of
// the port named by its select field; the upper lines come from aux_in.
// Assumes NUM_LINES > NUM_PIN_LINES. Purely combinational.
module xirq_src_mux
    import xirq_pkg::*;
#(
    parameter int NUM_LINES     = 23,
    parameter int NUM_PIN_LINES = 16,
    parameter int NUM_PORTS     = 8,
    localparam int SEL_W        = $clog2(NUM_PORTS),
    localparam int AUX_W        = NUM_LINES - NUM_PIN_LINES
) (
    input  logic [NUM_PORTS*NUM_PIN_LINES-1:0] gpio_in,
    input  logic [AUX_W-1:0]                   aux_in,
    input  logic [NUM_PIN_LINES*SEL_W-1:0]     sel_q,
    output logic [NUM_LINES-1:0]               line_o
);

    // Per-line port multiplexer plus pass-through of direct sources.
    always_comb begin
        line_o = '0;
        for (int i = 0; i < NUM_PIN_LINES; i++) begin
            for (int p = 0; p < NUM_PORTS; p++) begin
                if (sel_q[i*SEL_W +: SEL_W] == SEL_W'(p)) begin
                    line_o[i] = gpio_in[p*NUM_PIN_LINES + i];
                end
            end
        end
        line_o[NUM_LINES-1:NUM_PIN_LINES] = aux_in;
    end

endmodule

// File: rtl/xirq_edge_cap.sv
// Edge capture for one line. Two toggle flops, clocked by the line itself
// (rising and falling), record every enabled transition, however short the
// pulse. Each toggle is carried across SYNC_STAGES flops into the clk domain,
// and a change at the end of the chain is a one-cycle detection.
// The toggle flops carry no reset: during reset the chains load the current
// toggle value, so no detection appears at reset release.
// Assumes transitions on one line are spaced by more than SYNC_STAGES+1 clocks.
module xirq_edge_cap #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_in,
    input  logic rise_en,
    input  logic fall_en,
    output logic det_o
);

    logic                 rise_tog;
    logic                 fall_tog;
    logic [SYNC_STAGES:0] rise_chain;
    logic [SYNC_STAGES:0] fall_chain;

    // Record a rising transition by flipping the rising toggle.
    always_ff @(posedge line_in) begin
        rise_tog <= rise_tog ^ rise_en;
    end

    // Record a falling transition by flipping the falling toggle.
    always_ff @(negedge line_in) begin
        fall_tog <= fall_tog ^ fall_en;
    end

    // Synchronize both toggles into the clk domain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rise_chain <= {(SYNC_STAGES+1){rise_tog}};
            fall_chain <= {(SYNC_STAGES+1){fall_tog}};
        end else begin
            rise_chain <= {rise_chain[SYNC_STAGES-1:0], rise_tog};
            fall_chain <= {fall_chain[SYNC_STAGES-1:0], fall_tog};
        end
    end

    // A toggle change leaving the synchronizer marks one detection.
    always_comb begin
        det_o = (rise_chain[SYNC_STAGES] ^ rise_chain[SYNC_STAGES-1])
              | (fall_chain[SYNC_STAGES] ^ fall_chain[SYNC_STAGES-1]);
    end

endmodule

// File: rtl/xirq_regs.sv
// Register file: enables, trigger selects, software trigger, pending bits
// and port selection fields, with a registered read port.
// Software trigger bits raise a request only on a 0-to-1 write and fall
// back to 0 when the matching pending bit is cleared. A pending set beats
// a same-edge clear. Assumes NUM_LINES <= DATA_W.
module xirq_regs
    import xirq_pkg::*;
#(
    parameter int NUM_LINES     = 23,
    parameter int NUM_PIN_LINES = 16,
    parameter int SEL_W         = 3
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           bus_we,
    input  logic [ADDR_W-1:0]              bus_addr,
    input  logic [DATA_W-1:0]              bus_wdata,
    output logic [DATA_W-1:0]              bus_rdata,
    input  logic [NUM_LINES-1:0]           hw_det,
    output logic [NUM_LINES-1:0]           imask_q,
    output logic [NUM_LINES-1:0]           emask_q,
    output logic [NUM_LINES-1:0]           rise_q,
    output logic [NUM_LINES-1:0]           fall_q,
    output logic [NUM_LINES-1:0]           sw_q,
    output logic [NUM_LINES-1:0]           pend_q,
    output logic [NUM_LINES-1:0]           req_o,
    output logic [NUM_PIN_LINES*SEL_W-1:0] sel_q
);

    localparam int SEL_REGS = (NUM_PIN_LINES + FIELDS_PER_REG - 1) / FIELDS_PER_REG;

    logic [NUM_LINES-1:0] wr_bits;
    logic                 hit_int, hit_evt, hit_rise, hit_fall, hit_sw, hit_pend;
    logic [NUM_LINES-1:0] sw_set;
    logic [NUM_LINES-1:0] pend_clr;
    logic [DATA_W-1:0]    rd_word;

    // Decode the write strobe per register.
    always_comb begin
        wr_bits  = bus_wdata[NUM_LINES-1:0];
        hit_int  = bus_we && (bus_addr == A_INT_EN);
        hit_evt  = bus_we && (bus_addr == A_EVT_EN);
        hit_rise = bus_we && (bus_addr == A_RISE);
        hit_fall = bus_we && (bus_addr == A_FALL);
        hit_sw   = bus_we && (bus_addr == A_SWTRIG);
        hit_pend = bus_we && (bus_addr == A_PEND);
    end

    // Form software requests, clear masks and the merged request vector.
    always_comb begin
        sw_set   = hit_sw   ? (wr_bits & ~sw_q) : '0;
        pend_clr = hit_pend ? wr_bits : '0;
        req_o    = hw_det | sw_set;
    end

    // Plain read/write configuration registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            imask_q <= '0;
            emask_q <= '0;
            rise_q  <= '0;
            fall_q  <= '0;
        end else begin
            if (hit_int)  imask_q <= wr_bits;
            if (hit_evt)  emask_q <= wr_bits;
            if (hit_rise) rise_q  <= wr_bits;
            if (hit_fall) fall_q  <= wr_bits;
        end
    end

    // Pending bits: write-1 clear, enabled request sets, set wins.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= '0;
        end else begin
            pend_q <= (pend_q & ~pend_clr) | (req_o & imask_q);
        end
    end

    // Software trigger bits: set by writing 1, dropped with the pending clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sw_q <= '0;
        end else begin
            sw_q <= (sw_q & ~pend_clr) | sw_set;
        end
    end

    // Port selection fields, FIELDS_PER_REG per word starting at A_SEL0.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_q <= '0;
        end else begin
            for (int l = 0; l < NUM_PIN_LINES; l++) begin
                if (bus_we && (bus_addr == ADDR_W'(int'(A_SEL0) + l / FIELDS_PER_REG))) begin
                    sel_q[l*SEL_W +: SEL_W] <=
                        bus_wdata[(l % FIELDS_PER_REG)*SEL_FIELD_W +: SEL_W];
                end
            end
        end
    end

    // Read multiplexer for the addressed word.
    always_comb begin
        rd_word = '0;
        case (bus_addr)
            A_INT_EN: rd_word[NUM_LINES-1:0] = imask_q;
            A_EVT_EN: rd_word[NUM_LINES-1:0] = emask_q;
            A_RISE:   rd_word[NUM_LINES-1:0] = rise_q;
            A_FALL:   rd_word[NUM_LINES-1:0] = fall_q;
            A_SWTRIG: rd_word[NUM_LINES-1:0] = sw_q;
            A_PEND:   rd_word[NUM_LINES-1:0] = pend_q;
            default: begin
                for (int l = 0; l < NUM_PIN_LINES; l++) begin
                    if (bus_addr == ADDR_W'(int'(A_SEL0) + l / FIELDS_PER_REG)) begin
                        rd_word[(l % FIELDS_PER_REG)*SEL_FIELD_W +: SEL_W] =
                            sel_q[l*SEL_W +: SEL_W];
                    end
                end
            end
        endcase
    end

    // Register the read data one clock after the address.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bus_rdata <= '0;
        end else begin
            bus_rdata <= rd_word;
        end
    end

    // Number of selection words, kept for elaboration-time sanity.
    initial begin
        if (SEL_REGS > 2) $display("xirq_regs: more than two selection words");
    end

endmodule

// File: rtl/xirq_ctrl.sv
// Top of the external edge interrupt controller: source selection, one edge
// capture per line, register file and output shaping. Interrupt requests are
// levels (pending AND enable); events are one-cycle registered pulses.
// Assumes one clock for bus and logic and synchronous active-low reset.
module xirq_ctrl
    import xirq_pkg::*;
#(
    parameter int NUM_LINES     = 23,
    parameter int NUM_PIN_LINES = 16,
    parameter int NUM_PORTS     = 8,
    parameter int SYNC_STAGES   = 2,
    localparam int SEL_W        = $clog2(NUM_PORTS),
    localparam int AUX_W        = NUM_LINES - NUM_PIN_LINES
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic                               bus_we,
    input  logic [ADDR_W-1:0]                  bus_addr,
    input  logic [DATA_W-1:0]                  bus_wdata,
    output logic [DATA_W-1:0]                  bus_rdata,
    input  logic [NUM_PORTS*NUM_PIN_LINES-1:0] gpio_in,
    input  logic [AUX_W-1:0]                   aux_in,
    output logic [NUM_LINES-1:0]               irq_req,
    output logic [NUM_LINES-1:0]               evt_pulse
);

    logic [NUM_LINES-1:0]           line_sig;
    logic [NUM_LINES-1:0]           hw_det;
    logic [NUM_LINES-1:0]           imask_q, emask_q, rise_q, fall_q, sw_q, pend_q, req;
    logic [NUM_PIN_LINES*SEL_W-1:0] sel_q;
    logic [NUM_LINES-1:0]           evt_q;

    xirq_src_mux #(
        .NUM_LINES     (NUM_LINES),
        .NUM_PIN_LINES (NUM_PIN_LINES),
        .NUM_PORTS     (NUM_PORTS)
    ) u_mux (
        .gpio_in (gpio_in),
        .aux_in  (aux_in),
        .sel_q   (sel_q),
        .line_o  (line_sig)
    );

    for (genvar i = 0; i < NUM_LINES; i++) begin : g_cap
        xirq_edge_cap #(
            .SYNC_STAGES (SYNC_STAGES)
        ) u_cap (
            .clk     (clk),
            .rst_n   (rst_n),
            .line_in (line_sig[i]),
            .rise_en (rise_q[i]),
            .fall_en (fall_q[i]),
            .det_o   (hw_det[i])
        );
    end

    xirq_regs #(
        .NUM_LINES     (NUM_LINES),
        .NUM_PIN_LINES (NUM_PIN_LINES),
        .SEL_W         (SEL_W)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .hw_det    (hw_det),
        .imask_q   (imask_q),
        .emask_q   (emask_q),
        .rise_q    (rise_q),
        .fall_q    (fall_q),
        .sw_q      (sw_q),
        .pend_q    (pend_q),
        .req_o     (req),
        .sel_q     (sel_q)
    );

    // Event pulse: one cycle per request on lines with events enabled.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            evt_q <= '0;
        end else begin
            evt_q <= req & emask_q;
        end
    end

    // Output shaping of interrupt levels and event pulses.
    always_comb begin
        irq_req   = pend_q & imask_q;
        evt_pulse = evt_q;
    end

endmodule

// File: rtl/xirq_ctrl_chk.sv
// Assertion checker for xirq_ctrl, bound into every instance.
// Observes ports and register-file state; drives nothing.
module xirq_ctrl_chk
    import xirq_pkg::*;
#(
    parameter int NUM_LINES = 23
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 bus_we,
    input logic [ADDR_W-1:0]    bus_addr,
    input logic [DATA_W-1:0]    bus_wdata,
    input logic [NUM_LINES-1:0] irq_req,
    input logic [NUM_LINES-1:0] evt_pulse,
    input logic [NUM_LINES-1:0] pend,
    input logic [NUM_LINES-1:0] imask,
    input logic [NUM_LINES-1:0] emask,
    input logic [NUM_LINES-1:0] sw,
    input logic [NUM_LINES-1:0] req
);

    logic                 pend_wr;
    logic [NUM_LINES-1:0] clr_mask;

    // Bits a bus write to the pending register asks to clear.
    always_comb begin
        pend_wr  = bus_we && (bus_addr == A_PEND);
        clr_mask = pend_wr ? bus_wdata[NUM_LINES-1:0] : '0;
    end

    p_irq_needs_pend_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_req & ~pend) == '0);

    p_irq_masked_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_req & ~imask) == '0);

    p_evt_masked_r4: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((evt_pulse & ~$past(emask)) == '0));

    p_pend_needs_int_en_r5: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((pend & ~$past(pend) & ~$past(imask)) == '0));

    p_pend_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (($past(pend) & ~pend & ~$past(clr_mask)) == '0));

    p_pend_w1c_r5: assert property (@(posedge clk) disable iff (!rst_n)
        pend_wr |=> ((pend & $past(clr_mask) & ~$past(req)) == '0));

    p_sw_drop_r6: assert property (@(posedge clk) disable iff (!rst_n)
        pend_wr |=> ((sw & $past(clr_mask)) == '0));

    p_reset_clear_r9: assert property (@(posedge clk)
        !rst_n |=> (pend == '0 && imask == '0 && emask == '0 && evt_pulse == '0));

endmodule

bind xirq_ctrl xirq_ctrl_chk #(
    .NUM_LINES (NUM_LINES)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .irq_req   (irq_req),
    .evt_pulse (evt_pulse),
    .pend      (pend_q),
    .imask     (imask_q),
    .emask     (emask_q),
    .sw        (sw_q),
    .req       (req)
);

// File: tb/sim_xirq_ctrl.sv
// Self-checking bench: sweeps every line through every trigger mode, every
// pin line through every port, then masks, software trigger and clear races.
module sim_xirq_ctrl;
    import xirq_pkg::*;

    localparam int NL  = 23;
    localparam int NPL = 16;
    localparam int NP  = 8;
    localparam logic [31:0] ALL = 32'h007F_FFFF;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bus_we = 1'b0;
    logic [3:0]    bus_addr = '0;
    logic [31:0]   bus_wdata = '0;
    logic [31:0]   bus_rdata;
    logic [127:0]  gpio_in = '0;
    logic [6:0]    aux_in = '0;
    logic [NL-1:0] irq_req;
    logic [NL-1:0] evt_pulse;

    int vectors = 0;
    int miscompares = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    xirq_ctrl u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .gpio_in   (gpio_in),
        .aux_in    (aux_in),
        .irq_req   (irq_req),
        .evt_pulse (evt_pulse)
    );

    task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic wr(logic [3:0] a, logic [31:0] d);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk); #1;
        bus_we = 1'b0;
    endtask

    task automatic rd(logic [3:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a;
        @(posedge clk); #1;
        d = bus_rdata;
    endtask

    task automatic drive(int ln, int port, logic v);
        if (ln < NPL) gpio_in[port*NPL + ln] = v;
        else          aux_in[ln - NPL] = v;
    endtask

    // Narrow pulse, 1 ns wide, well under the 4 ns clock period.
    task automatic pulse(int ln, int port);
        drive(ln, port, 1'b1);
        #1;
        drive(ln, port, 1'b0);
    endtask

    // Request takes effect on the third rising edge after the transition.
    task automatic wait_req();
        repeat (3) @(posedge clk);
        #1;
    endtask

    function automatic logic [31:0] bit_of(int ln);
        return 32'(1) << ln;
    endfunction

    initial begin
        logic [31:0] d;
        logic [31:0] exp;

        repeat (3) @(posedge clk);
        #1;
        rst_n = 1'b1;

        // R9: reset state at the ports and in every register.
        check("R9", "irq after reset", 32'(irq_req), 32'h0);
        check("R9", "evt after reset", 32'(evt_pulse), 32'h0);
        for (int a = 0; a < 8; a++) begin
            rd(4'(a), d);
            check("R9", $sformatf("reg %0d after reset", a), d, 32'h0);
        end

        // R8: readback and unused bits.
        wr(A_INT_EN, 32'hFFFF_FFFF);
        rd(A_INT_EN, d); check("R8", "INT_EN readback", d, ALL);
        wr(A_RISE, 32'h2AAA_AAAA);
        rd(A_RISE, d); check("R8", "RISE readback", d, 32'h002A_AAAA);
        wr(A_SEL0, 32'h7654_3210);
        rd(A_SEL0, d); check("R8", "SEL0 readback", d, 32'h7654_3210);
        wr(4'(int'(A_SEL0) + 1), 32'hFFFF_FFFF);
        rd(4'(int'(A_SEL0) + 1), d); check("R8", "SEL1 readback", d, 32'h7777_7777);
        wr(A_SEL0, 32'h0);
        wr(4'(int'(A_SEL0) + 1), 32'h0);

        // R1/R2/R4: every line, every trigger mode, step up then step down.
        wr(A_INT_EN, ALL);
        wr(A_EVT_EN, ALL);
        for (int ln = 0; ln < NL; ln++) begin
            for (int mode = 0; mode < 4; mode++) begin
                wr(A_RISE, mode[0] ? ALL : 32'h0);
                wr(A_FALL, mode[1] ? ALL : 32'h0);
                drive(ln, 0, 1'b1);
                wait_req();
                exp = mode[0] ? bit_of(ln) : 32'h0;
                check("R1", $sformatf("evt rise line %0d mode %0d", ln, mode), 32'(evt_pulse), exp);
                check("R3", $sformatf("irq rise line %0d mode %0d", ln, mode), 32'(irq_req), exp);
                @(posedge clk); #1;
                check("R4", $sformatf("evt one cycle line %0d", ln), 32'(evt_pulse), 32'h0);
                wr(A_PEND, ALL);
                check("R5", $sformatf("clear line %0d", ln), 32'(irq_req), 32'h0);
                drive(ln, 0, 1'b0);
                wait_req();
                exp = mode[1] ? bit_of(ln) : 32'h0;
                check("R1", $sformatf("evt fall line %0d mode %0d", ln, mode), 32'(evt_pulse), exp);
                check("R3", $sformatf("irq fall line %0d mode %0d", ln, mode), 32'(irq_req), exp);
                wr(A_PEND, ALL);
            end
        end

        // R7/R2: every pin line from every port with narrow pulses.
        wr(A_RISE, ALL);
        wr(A_FALL, 32'h0);
        for (int p = 0; p < NP; p++) begin
            d = '0;
            for (int j = 0; j < 8; j++) d[j*4 +: 4] = 4'(p);
            wr(A_SEL0, d);
            wr(4'(int'(A_SEL0) + 1), d);
            for (int ln = 0; ln < NPL; ln++) begin
                pulse(ln, p);
                wait_req();
                check("R2", $sformatf("narrow pulse line %0d port %0d", ln, p), 32'(irq_req), bit_of(ln));
                wr(A_PEND, ALL);
                pulse(ln, (p + 1) % NP);
                wait_req();
                check("R7", $sformatf("other port line %0d port %0d", ln, p), 32'(evt_pulse), 32'h0);
                check("R7", $sformatf("other port irq line %0d port %0d", ln, p), 32'(irq_req), 32'h0);
            end
        end
        wr(A_SEL0, 32'h0);
        wr(4'(int'(A_SEL0) + 1), 32'h0);

        // R4/R5: event enabled, interrupt masked, on direct line 20.
        wr(A_INT_EN, 32'h0);
        pulse(20, 0);
        wait_req();
        check("R4", "evt with INT_EN off", 32'(evt_pulse), bit_of(20));
        check("R3", "irq with INT_EN off", 32'(irq_req), 32'h0);
        rd(A_PEND, d); check("R5", "pend not set when masked", d, 32'h0);
        wr(A_INT_EN, ALL);
        check("R3", "no late irq after enable", 32'(irq_req), 32'h0);

        // R4/R3: interrupt enabled, event masked.
        wr(A_EVT_EN, 32'h0);
        pulse(20, 0);
        wait_req();
        check("R4", "evt masked", 32'(evt_pulse), 32'h0);
        check("R3", "irq with event off", 32'(irq_req), bit_of(20));
        rd(A_PEND, d); check("R5", "pend set", d, bit_of(20));
        wr(A_INT_EN, 32'h0);
        check("R3", "irq gated by INT_EN", 32'(irq_req), 32'h0);
        rd(A_PEND, d); check("R5", "pend kept while masked", d, bit_of(20));
        wr(A_INT_EN, ALL);
        check("R3", "irq back after enable", 32'(irq_req), bit_of(20));
        wr(A_PEND, 32'h0);
        check("R5", "write 0 ignored", 32'(irq_req), bit_of(20));
        wr(A_PEND, bit_of(20));
        check("R5", "write 1 clears", 32'(irq_req), 32'h0);
        wr(A_EVT_EN, ALL);

        // R6: software trigger.
        wr(A_SWTRIG, bit_of(5));
        check("R6", "sw irq", 32'(irq_req), bit_of(5));
        check("R6", "sw evt", 32'(evt_pulse), bit_of(5));
        @(posedge clk); #1;
        check("R4", "sw evt one cycle", 32'(evt_pulse), 32'h0);
        rd(A_SWTRIG, d); check("R6", "sw bit reads 1", d, bit_of(5));
        wr(A_SWTRIG, bit_of(5));
        check("R6", "rewrite makes no event", 32'(evt_pulse), 32'h0);
        wr(A_PEND, bit_of(5));
        check("R6", "irq cleared", 32'(irq_req), 32'h0);
        rd(A_SWTRIG, d); check("R6", "sw bit dropped", d, 32'h0);
        wr(A_INT_EN, 32'h0);
        wr(A_SWTRIG, bit_of(7));
        check("R6", "sw evt while masked", 32'(evt_pulse), bit_of(7));
        rd(A_PEND, d); check("R5", "sw pend masked", d, 32'h0);
        rd(A_SWTRIG, d); check("R6", "sw bit held", d, bit_of(7));
        wr(A_PEND, bit_of(7));
        rd(A_SWTRIG, d); check("R6", "sw bit dropped by clear", d, 32'h0);
        wr(A_INT_EN, ALL);

        // R5: request and clear on the same edge, set wins.
        pulse(9, 0);
        @(posedge clk);
        @(posedge clk);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = A_PEND; bus_wdata = bit_of(9);
        @(posedge clk); #1;
        bus_we = 1'b0;
        check("R5", "set wins over clear", 32'(irq_req), bit_of(9));
        wr(A_PEND, bit_of(9));
        check("R5", "later clear", 32'(irq_req), 32'h0);

        // R9: reset in mid-run.
        wr(A_SWTRIG, bit_of(2));
        @(negedge clk); rst_n = 1'b0;
        repeat (2) @(posedge clk);
        #1;
        check("R9", "irq in reset", 32'(irq_req), 32'h0);
        rst_n = 1'b1;
        for (int a = 0; a < 8; a++) begin
            rd(4'(a), d);
            check("R9", $sformatf("reg %0d after mid reset", a), d, 32'h0);
        end

        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            miscompares++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

endmodule